// File: doc/BRIEF.md
# E1 Non-Alignment Timeslot-Zero Transmit Builder

This block forms the timeslot-zero byte sent in every frame of a 2.048 Mb/s E1 transmit stream that does not carry the frame alignment word. The byte holds the international Si bit, a fixed one, the remote alarm (A) bit and five national spare bits Sa4 to Sa8. A host processor writes the spare bits and a remote-alarm request through a simple write port. The A bit is raised whenever the host asks for it, when local frame alignment is lost, or when a receive error indication is present and not masked.

Two write-pending flags let the host know when its data has reached the line. The main flag covers the five spare bits. A second flag covers a four-bit Sa6 subchannel nibble, which is sent one bit per non-alignment frame when the subchannel is enabled. Each flag clears after either one transmission or three consecutive transmissions, according to its own filter mode input. A new write while a flag is still set replaces the pending data and starts the count again.

The surrounding framer supplies a strobe in the cycle in which each non-alignment timeslot zero is sent. The output byte is valid at all times and is taken by the framer at that strobe.

Top module: `e1_nfas_ts0_gen`

## Requirements
- R1: After reset both pending flags are 0, the stored spare bits are all 1, the stored remote-alarm request is 0, the Sa6 nibble is all 1 and its bit pointer is at the first bit.
- R2: The output byte carries Si in bit 7, a constant 1 in bit 6, and the stored spare bits in bits 4 down to 0 with Sa4 in bit 4 and Sa8 in bit 0 (write data bit 4 is Sa4, bit 0 is Sa8); with the subchannel disabled bit 2 is the stored Sa6 bit.
- R3: Output bit 5 (the A bit) is 1 exactly when the stored alarm request is 1, or loss of frame is 1, or the receive error input is 1 while the error mask input is 0.
- R4: A main write sets the main pending flag at the following clock edge; an Sa6 write sets the Sa6 pending flag likewise.
- R5: With the main filter mode at 0, the main pending flag clears at the first strobe after the write.
- R6: With the main filter mode at 1, the main pending flag clears at the third strobe after the write; a new write while pending restarts the count at zero.
- R7: With the subchannel enabled, output bit 2 carries the Sa6 nibble one bit per strobe, write data bit 3 (Sa61) first and bit 0 (Sa64) last, then repeats; an Sa6 write returns the pointer to bit 3.
- R8: The Sa6 pending flag clears after one completed nibble when its filter mode is 0 and after three completed nibbles when it is 1; an Sa6 write while pending restarts both pointer and count.
- R9: A write in the same cycle as a strobe takes priority: the flag stays set with a count of zero and the strobe is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nfas_stb | input | 1 | Marks the cycle a non-alignment timeslot zero is sent |
| si_bit | input | 1 | International bit for output bit 7 |
| lof_in | input | 1 | Local loss of frame alignment |
| rx_err_in | input | 1 | Receive error indication |
| rx_err_mask | input | 1 | 1 masks rx_err_in from the A bit |
| main_wr | input | 1 | Write strobe for spare bits and alarm request |
| main_wr_sa | input | 5 | Sa4 (bit 4) to Sa8 (bit 0) |
| main_wr_alarm | input | 1 | Remote alarm request |
| main_filt | input | 1 | 1 selects three transmissions for the main flag |
| sub_en | input | 1 | 1 sends the Sa6 nibble serially in bit 2 |
| sub_wr | input | 1 | Write strobe for the Sa6 nibble |
| sub_wr_nib | input | 4 | Sa61 (bit 3) to Sa64 (bit 0) |
| sub_filt | input | 1 | 1 selects three nibbles for the Sa6 flag |
| ts0_byte | output | 8 | Non-alignment timeslot-zero byte, bit 7 sent first |
| main_pending | output | 1 | Spare-bit word not yet fully sent |
| sub_pending | output | 1 | Sa6 nibble not yet fully sent |

## Verification
The bench chases the filter-of-three count across interleaved writes, where a design that failed to restart would clear one or two frames early. It lands writes on strobe cycles, where a design giving the strobe priority would count a transmission of the stale word. It toggles the subchannel enable mid-stream and checks the nibble ordering and its wrap, where a reversed or stalled pointer would put Sa64 first or repeat one bit. It sweeps all alarm and mask combinations, where an unmasked error or a dropped source would show in bit 5.

// File: rtl/e1_ts0_pkg.sv
package e1_ts0_pkg;
   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned POS_SI  = 7;
   localparam int unsigned POS_ONE = 6;
   localparam int unsigned POS_A   = 5;
   localparam int unsigned SPARE_W = 5;
   // index of Sa6 within the spare field (Sa4 at 4 ... Sa8 at 0)
   localparam int unsigned SA6_IDX = 2;
endpackage

// File: rtl/e1_ts0_pend.sv
module e1_ts0_pend #(
   parameter int unsigned REPEAT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic tx_evt,
   input  logic filt,
   output logic pending
);
   localparam int unsigned CW = $clog2(REPEAT + 1);

   generate
      if (REPEAT < 2) begin : g_bad_repeat
         $error("REPEAT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] target;
   logic          pend_q;

   assign target  = filt ? CW'(REPEAT) : CW'(1);
   assign pending = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (load) begin
         pend_q <= 1'b1;
         cnt_q  <= '0;
      end else if (pend_q && tx_evt) begin
         if (cnt_q + CW'(1) >= target) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   p_set_on_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> pending);
   p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !load && !tx_evt) |=> pending);
   p_single_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !load && tx_evt && !filt) |=> !pending);
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(REPEAT));
   p_idle_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending && !load) |=> !pending);
endmodule

// File: rtl/e1_sa6_ser.sv
module e1_sa6_ser #(
   parameter int unsigned NIB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [NIB_W-1:0] nib_in,
   input  logic             advance,
   output logic             bit_out,
   output logic             nib_done
);
   localparam int unsigned IW = (NIB_W > 1) ? $clog2(NIB_W) : 1;
   localparam logic [IW-1:0] LAST = IW'(NIB_W - 1);

   generate
      if (NIB_W < 2) begin : g_bad_nib
         $error("NIB_W must be at least 2");
      end
   endgenerate

   logic [NIB_W-1:0] nib_q;
   logic [IW-1:0]    idx_q;

   assign bit_out  = nib_q[LAST - idx_q];
   assign nib_done = advance && (idx_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nib_q <= '1;
         idx_q <= '0;
      end else if (load) begin
         nib_q <= nib_in;
         idx_q <= '0;
      end else if (advance) begin
         idx_q <= (idx_q == LAST) ? '0 : idx_q + IW'(1);
      end
   end

   p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && idx_q != LAST) |=> idx_q == $past(idx_q) + IW'(1));
   p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && idx_q == LAST) |=> idx_q == '0);
   p_ptr_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> idx_q == '0);
   p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !load) |=> $stable(idx_q));
endmodule

// File: rtl/e1_nfas_ts0_gen.sv
module e1_nfas_ts0_gen
   import e1_ts0_pkg::*;
#(
   parameter int unsigned FILT_REPEAT = 3,
   parameter int unsigned SUB_NIB_W   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 nfas_stb,
   input  logic                 si_bit,
   input  logic                 lof_in,
   input  logic                 rx_err_in,
   input  logic                 rx_err_mask,
   input  logic                 main_wr,
   input  logic [SPARE_W-1:0]   main_wr_sa,
   input  logic                 main_wr_alarm,
   input  logic                 main_filt,
   input  logic                 sub_en,
   input  logic                 sub_wr,
   input  logic [SUB_NIB_W-1:0] sub_wr_nib,
   input  logic                 sub_filt,
   output logic [BYTE_W-1:0]    ts0_byte,
   output logic                 main_pending,
   output logic                 sub_pending
);
   logic [SPARE_W-1:0] sa_q;
   logic [SPARE_W-1:0] sa_out;
   logic               alarm_q;
   logic               a_bit;
   logic               sub_bit;
   logic               sub_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sa_q    <= '1;
         alarm_q <= 1'b0;
      end else if (main_wr) begin
         sa_q    <= main_wr_sa;
         alarm_q <= main_wr_alarm;
      end
   end

   assign a_bit = alarm_q | lof_in | (rx_err_in & ~rx_err_mask);

   generate
      for (genvar k = 0; k < SPARE_W; k++) begin : g_spare
         if (k == SA6_IDX) begin : g_sub
            assign sa_out[k] = sub_en ? sub_bit : sa_q[k];
         end else begin : g_fixed
            assign sa_out[k] = sa_q[k];
         end
      end
   endgenerate

   assign ts0_byte = {si_bit, 1'b1, a_bit, sa_out};

   e1_sa6_ser #(.NIB_W(SUB_NIB_W)) u_sub_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sub_wr),
      .nib_in   (sub_wr_nib),
      .advance  (nfas_stb && sub_en),
      .bit_out  (sub_bit),
      .nib_done (sub_done)
   );

   e1_ts0_pend #(.REPEAT(FILT_REPEAT)) u_main_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (main_wr),
      .tx_evt  (nfas_stb),
      .filt    (main_filt),
      .pending (main_pending)
   );

   e1_ts0_pend #(.REPEAT(FILT_REPEAT)) u_sub_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (sub_wr),
      .tx_evt  (sub_done),
      .filt    (sub_filt),
      .pending (sub_pending)
   );

   p_sa_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !main_wr |=> $stable(sa_q));
   p_alarm_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lof_in || alarm_q) |-> ts0_byte[POS_A]);
   p_wr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (main_wr && nfas_stb) |=> main_pending);
endmodule

// File: tb/test_e1_nfas_ts0_gen.sv
module test_e1_nfas_ts0_gen;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stb = 0, si = 0, lof = 0, err = 0, mask = 0;
   logic mwr = 0, malarm = 0, mfilt = 0;
   logic [4:0] msa = '0;
   logic sen = 0, swr = 0, sfilt = 0;
   logic [3:0] snib = '0;
   logic [7:0] byte_o;
   logic mpend, spend;

   int checks = 0, errors = 0, cyc = 0;

   // bench model state
   logic [4:0] m_sa = '1;
   logic       m_alarm = 0;
   logic [3:0] m_nib = '1;
   int m_idx = 0, m_mcnt = 0, m_scnt = 0;
   logic m_mpend = 0, m_spend = 0;

   always #10 clk = ~clk;

   e1_nfas_ts0_gen i_e1_nfas_ts0_gen (
      .clk(clk), .rst_n(rst_n), .nfas_stb(stb), .si_bit(si), .lof_in(lof),
      .rx_err_in(err), .rx_err_mask(mask), .main_wr(mwr), .main_wr_sa(msa),
      .main_wr_alarm(malarm), .main_filt(mfilt), .sub_en(sen), .sub_wr(swr),
      .sub_wr_nib(snib), .sub_filt(sfilt), .ts0_byte(byte_o),
      .main_pending(mpend), .sub_pending(spend));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic exp_a();
      return m_alarm | lof | (err & ~mask);
   endfunction

   function automatic logic [7:0] exp_byte();
      logic [4:0] s;
      s = m_sa;
      if (sen) s[2] = m_nib[3 - m_idx];
      return {si, 1'b1, exp_a(), s};
   endfunction

   // check current outputs, then advance model to the next edge
   task automatic step();
      #1;
      chk("R2 layout", {byte_o[7:6], byte_o[4:0]}, {exp_byte() >> 7, exp_byte() >> 6 & 1'b1, exp_byte()} & 0 | {exp_byte()[7:6], exp_byte()[4:0]});
      chk("R3 A bit", byte_o[5], exp_a());
      if (sen) chk("R7 Sa6 serial bit", byte_o[2], m_nib[3 - m_idx]);
      chk(mfilt ? "R6 main pending" : "R5 main pending", mpend, m_mpend);
      chk("R8 sub pending", spend, m_spend);
      // model next state
      if (mwr) begin
         m_sa = msa; m_alarm = malarm; m_mpend = 1; m_mcnt = 0;
      end else if (m_mpend && stb) begin
         if (m_mcnt + 1 >= (mfilt ? 3 : 1)) begin m_mpend = 0; m_mcnt = 0; end
         else m_mcnt++;
      end
      if (swr) begin
         m_nib = snib; m_idx = 0; m_spend = 1; m_scnt = 0;
      end else if (stb && sen) begin
         if (m_idx == 3 && m_spend) begin
            if (m_scnt + 1 >= (sfilt ? 3 : 1)) begin m_spend = 0; m_scnt = 0; end
            else m_scnt++;
         end
         m_idx = (m_idx + 1) % 4;
      end
      @(negedge clk);
   endtask

   task automatic idle_in();
      stb = 0; mwr = 0; swr = 0;
   endtask

   initial begin
      void'($urandom(32'h5A17));
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      // R1 reset state
      #1;
      chk("R1 main pending", mpend, 0);
      chk("R1 sub pending", spend, 0);
      chk("R1 spare bits", byte_o[4:0], 5'h1F);
      chk("R1 alarm clear", byte_o[5], 0);
      @(negedge clk);
      // R4 / R5 directed: write, then one strobe clears with filt 0
      mwr = 1; msa = 5'h0A; malarm = 0; step(); idle_in();
      #1 chk("R4 set after write", mpend, 1);
      chk("R2 Sa4 in bit 4", byte_o[4:0], 5'h0A);
      stb = 1; step(); idle_in();
      #1 chk("R5 cleared after one", mpend, 0);
      // R6 directed: filt 1, restart on rewrite
      mfilt = 1; mwr = 1; msa = 5'h15; step(); idle_in();
      stb = 1; step(); step(); idle_in();
      mwr = 1; step(); idle_in();
      stb = 1; step(); step(); idle_in();
      #1 chk("R6 still pending after restart", mpend, 1);
      stb = 1; step(); idle_in();
      #1 chk("R6 cleared after third", mpend, 0);
      // R9 directed: write on strobe
      mfilt = 0; mwr = 1; stb = 1; step(); idle_in();
      #1 chk("R9 write wins over strobe", mpend, 1);
      // R7/R8 directed: nibble order
      sen = 1; sfilt = 0; swr = 1; snib = 4'b1000; step(); idle_in();
      #1 chk("R7 Sa61 first", byte_o[2], 1);
      stb = 1; step(); idle_in();
      #1 chk("R7 Sa62 second", byte_o[2], 0);
      stb = 1; step(); step(); step(); idle_in();
      #1 chk("R8 cleared after nibble", spend, 0);
      // R3 sweep
      for (int v = 0; v < 16; v++) begin
         {malarm, lof, err, mask} = v[3:0];
         mwr = 1; step(); idle_in(); step();
      end
      // random phase
      for (int n = 0; n < 4000; n++) begin
         stb    = ($urandom % 3) == 0;
         si     = $urandom;
         lof    = ($urandom % 8) == 0;
         err    = $urandom;
         mask   = $urandom;
         mwr    = ($urandom % 12) == 0;
         msa    = $urandom;
         malarm = ($urandom % 4) == 0;
         if (($urandom % 50) == 0) mfilt = ~mfilt;
         if (($urandom % 80) == 0) sen = ~sen;
         swr    = ($urandom % 30) == 0;
         snib   = $urandom;
         if (($urandom % 60) == 0) sfilt = ~sfilt;
         step();
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected below 100000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule